// File: doc/BRIEF.md
# Receive PHY Control Bridge

This block sits between a host bus and the control side of a receive PHY. The host sees one port with read, write, waitrequest and 32-bit data, and addresses it in bytes, one register every four bytes. The lowest 4 KiB of the host map is a window onto the transceiver reconfiguration space. The bridge divides the host offset by four before it drives the reconfiguration address, so host address 0x0400 reaches reconfiguration offset 0x100. A channel-select register steers the window to one of three reconfiguration ports, and an enable register opens or closes the window. When the window is closed, or the channel select points past the last port, window accesses finish at once: reads return zero and writes are dropped.

Above the window sits a small register bank, one register per 16-byte slot starting at 0x1000. It holds a clock-measurement word and its valid flag, calibration-done and calibration-busy flags, the channel select, the window enable, the receiver reset, a live mirror of the selected port's waitrequest, and a fixed configuration flag. The measurement logic, the transceiver and the PLLs are outside this block, and their status arrives on plain inputs.

The control state machine has two states. `S_IDLE` is the resting state. Every register access and every unstalled window access completes here. `S_FWD_STALL` is entered from `S_IDLE` when an open window access meets a high waitrequest on the selected port. While in `S_FWD_STALL`, the port chosen at entry stays routed. The machine returns to `S_IDLE` once that waitrequest drops or the host withdraws the access. Read data of every completed read appears on the cycle after the read completes.

Top module: `phyb_ctrl_bridge`

## Requirements
- R1: With the window enabled and a channel select of 0 to 2, a host access below 0x1000 drives exactly one read or write strobe, on the selected port. The reconfiguration address is host address bits [11:2], and the write data passes through unchanged.
- R2: The channel select sits at 0x1040 in bits [1:0]. It is read/write and resets to 0. Code n (0 to 2) routes window accesses to port n, and the strobes of every other port stay low.
- R3: The window enable sits at 0x1050 in bit 0. It is read/write and resets to 0. While it is 0, no strobe reaches any reconfiguration port.
- R4: A window access made while the window is disabled, or while the channel select is 3, completes with no stall. A read returns 0, and a write reaches no port.
- R5: During an open window access, the host waitrequest equals the selected port's waitrequest. The access completes on the first cycle in which that waitrequest is low.
- R6: The data of a completed read is on hst_rdata in the cycle after the read completes. A window read returns the port data present in its completion cycle. In every other cycle hst_rdata is 0.
- R7: The receiver reset sits at 0x1060 in bit 0. It is read/write, resets to 0, and drives rx_reset directly.
- R8: The read-only bit 0 at 0x1070 returns the live waitrequest of the selected port, or 0 while the channel select is 3.
- R9: Read-only status: 0x1000 returns the 32-bit measurement, 0x1010 bit 0 returns its valid flag, 0x1020 bit 0 returns calibration done, and 0x1030 bit 0 returns calibration busy.
- R10: The configuration flag at 0x10B0 always reads 0, which means the integer PLL source.
- R11: Unused upper bits of every register read as 0 and ignore writes, and writes to read-only registers have no effect.
- R12: Register and unmapped accesses at or above 0x1000 never stall. Unmapped reads return 0, and unmapped writes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 16 | Host byte address |
| hst_read | input | 1 | Host read request |
| hst_write | input | 1 | Host write request |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after completion |
| hst_waitreq | output | 1 | Host stall |
| xcfg_addr | output | 10 | Reconfiguration offset, shared by all ports |
| xcfg_wdata | output | 32 | Reconfiguration write data, shared |
| xcfg_read | output | 3 | Per-port read strobe |
| xcfg_write | output | 3 | Per-port write strobe |
| xcfg_rdata | input | 96 | Per-port read data, port n in bits [32n+31:32n] |
| xcfg_waitreq | input | 3 | Per-port waitrequest |
| meas_count | input | 32 | Clock measurement value |
| meas_ok | input | 1 | Measurement valid |
| cal_done | input | 1 | Power-up calibration complete |
| cal_busy | input | 1 | Receiver calibration in progress |
| rx_reset | output | 1 | Receiver reset |

## Verification
The waitrequest mirror and the forwarding stall path can be active in the same cycle. The selected port holds its waitrequest high, and that same signal is what stalls window traffic. The bench holds a port's waitrequest high with no window traffic and reads 0x1070. The read must complete with zero stall cycles and return 1; a stalled host would show the register path wrongly tied to the forwarding stall. A window access to that port then stalls for exactly the programmed number of cycles and returns that port's data.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

    typedef enum logic {
        S_IDLE,
        S_FWD_STALL
    } fsm_t;

    typedef enum logic [1:0] {
        AR_NONE,
        AR_WIN,
        AR_REG
    } region_t;

    localparam logic [3:0] IX_MEAS   = 4'h0;
    localparam logic [3:0] IX_VALID  = 4'h1;
    localparam logic [3:0] IX_CDONE  = 4'h2;
    localparam logic [3:0] IX_CBUSY  = 4'h3;
    localparam logic [3:0] IX_CHAN   = 4'h4;
    localparam logic [3:0] IX_EN     = 4'h5;
    localparam logic [3:0] IX_RST    = 4'h6;
    localparam logic [3:0] IX_MIRROR = 4'h7;
    localparam logic [3:0] IX_CFG    = 4'hB;

endpackage

// File: rtl/phyb_decode.sv
module phyb_decode
    import phyb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_AW = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [3:0]        reg_idx
);
    localparam int unsigned WIN_BASE = 32'd1 << WIN_AW;
    localparam int unsigned REG_END  = WIN_BASE + 32'd256;

    logic [31:0] addr_ext;

    always_comb begin
        addr_ext = 32'(addr);
        reg_idx  = addr[7:4];
        if (addr_ext < WIN_BASE)
            region = AR_WIN;
        else if (addr_ext < REG_END && addr[3:0] == 4'h0)
            region = AR_REG;
        else
            region = AR_NONE;
    end
endmodule

// File: rtl/phyb_regbank.sv
module phyb_regbank
    import phyb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [3:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] meas_count,
    input  logic              meas_ok,
    input  logic              cal_done,
    input  logic              cal_busy,
    input  logic              mirror_wait,
    output logic [CH_W-1:0]   chan_q,
    output logic              en_q,
    output logic              rst_q,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic CFG_FLAG = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            en_q   <= 1'b0;
            rst_q  <= 1'b0;
        end else if (wr_stb) begin
            unique case (idx)
                IX_CHAN: chan_q <= wdata[CH_W-1:0];
                IX_EN:   en_q   <= wdata[0];
                IX_RST:  rst_q  <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IX_MEAS:   rd_val = meas_count;
            IX_VALID:  rd_val = DATA_W'(meas_ok);
            IX_CDONE:  rd_val = DATA_W'(cal_done);
            IX_CBUSY:  rd_val = DATA_W'(cal_busy);
            IX_CHAN:   rd_val = DATA_W'(chan_q);
            IX_EN:     rd_val = DATA_W'(en_q);
            IX_RST:    rd_val = DATA_W'(rst_q);
            IX_MIRROR: rd_val = DATA_W'(mirror_wait);
            IX_CFG:    rd_val = DATA_W'(CFG_FLAG);
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/phyb_fwd_mux.sv
module phyb_fwd_mux #(
    parameter int NCH    = 3,
    parameter int DATA_W = 32,
    parameter int CH_W   = 2
) (
    input  logic [CH_W-1:0]       chan,
    input  logic                  fwd_ok,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [NCH*DATA_W-1:0] port_rdata,
    input  logic [NCH-1:0]        port_wait,
    output logic [NCH-1:0]        port_rd,
    output logic [NCH-1:0]        port_wr,
    output logic [DATA_W-1:0]     sel_rdata,
    output logic                  sel_wait
);
    for (genvar g = 0; g < NCH; g++) begin : g_port
        logic hit;
        assign hit        = fwd_ok && (chan == CH_W'(g));
        assign port_rd[g] = hit && rd;
        assign port_wr[g] = hit && wr;
    end

    always_comb begin
        sel_rdata = '0;
        sel_wait  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (chan == CH_W'(i)) begin
                sel_rdata = port_rdata[i*DATA_W +: DATA_W];
                sel_wait  = port_wait[i];
            end
        end
    end
endmodule

// File: rtl/phyb_ctrl_bridge.sv
module phyb_ctrl_bridge
    import phyb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NCH     = 3,
    parameter int WIN_AW  = 12,
    parameter int XADDR_W = WIN_AW - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     hst_addr,
    input  logic                  hst_read,
    input  logic                  hst_write,
    input  logic [DATA_W-1:0]     hst_wdata,
    output logic [DATA_W-1:0]     hst_rdata,
    output logic                  hst_waitreq,
    output logic [XADDR_W-1:0]    xcfg_addr,
    output logic [DATA_W-1:0]     xcfg_wdata,
    output logic [NCH-1:0]        xcfg_read,
    output logic [NCH-1:0]        xcfg_write,
    input  logic [NCH*DATA_W-1:0] xcfg_rdata,
    input  logic [NCH-1:0]        xcfg_waitreq,
    input  logic [DATA_W-1:0]     meas_count,
    input  logic                  meas_ok,
    input  logic                  cal_done,
    input  logic                  cal_busy,
    output logic                  rx_reset
);
    localparam int CH_W = (NCH < 2) ? 1 : $clog2(NCH + 1);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    fsm_t              state, state_n;
    region_t           region;
    logic [3:0]        reg_idx;
    logic [CH_W-1:0]   chan_q, chan_hold, chan_route;
    logic              en_q;
    logic              access, fwd_ok, fwd_go, done;
    logic              sel_wait;
    logic [DATA_W-1:0] sel_rdata, reg_val, rd_next, rdata_q;

    phyb_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
        .addr    (hst_addr),
        .region  (region),
        .reg_idx (reg_idx)
    );

    phyb_regbank #(.DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (done && hst_write && region == AR_REG),
        .idx         (reg_idx),
        .wdata       (hst_wdata),
        .meas_count  (meas_count),
        .meas_ok     (meas_ok),
        .cal_done    (cal_done),
        .cal_busy    (cal_busy),
        .mirror_wait (sel_wait),
        .chan_q      (chan_q),
        .en_q        (en_q),
        .rst_q       (rx_reset),
        .rd_val      (reg_val)
    );

    phyb_fwd_mux #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) u_mux (
        .chan       (chan_route),
        .fwd_ok     (fwd_ok),
        .rd         (hst_read),
        .wr         (hst_write),
        .port_rdata (xcfg_rdata),
        .port_wait  (xcfg_waitreq),
        .port_rd    (xcfg_read),
        .port_wr    (xcfg_write),
        .sel_rdata  (sel_rdata),
        .sel_wait   (sel_wait)
    );

    // Routing and completion
    always_comb begin
        chan_route = (state == S_FWD_STALL) ? chan_hold : chan_q;
        access     = hst_read || hst_write;
        fwd_ok     = (region == AR_WIN) && en_q && (chan_route <= LAST_CH);
        fwd_go     = access && fwd_ok;
        done       = access && !hst_waitreq;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            chan_hold <= '0;
        end else begin
            state <= state_n;
            if (state == S_IDLE)
                chan_hold <= chan_q;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n     = state;
        hst_waitreq = fwd_go && sel_wait;
        xcfg_addr   = hst_addr[WIN_AW-1:2];
        xcfg_wdata  = hst_wdata;
        unique case (state)
            S_IDLE:      if (fwd_go && sel_wait)    state_n = S_FWD_STALL;
            S_FWD_STALL: if (!fwd_go || !sel_wait)  state_n = S_IDLE;
            default:                                state_n = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (region)
            AR_WIN:  rd_next = fwd_ok ? sel_rdata : '0;
            AR_REG:  rd_next = reg_val;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= (hst_read && !hst_waitreq) ? rd_next : '0;
    end

    assign hst_rdata = rdata_q;
endmodule

// File: rtl/phyb_ctrl_bridge_chk.sv
module phyb_ctrl_bridge_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NCH    = 3,
    parameter int WIN_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              hst_read,
    input logic              hst_write,
    input logic              hst_waitreq,
    input logic [DATA_W-1:0] hst_rdata,
    input logic [NCH-1:0]    xcfg_read,
    input logic [NCH-1:0]    xcfg_write,
    input logic              rx_reset
);
    localparam int unsigned WIN_BASE = 32'd1 << WIN_AW;

    logic [31:0] a32;
    logic        any_stb;
    assign a32     = 32'(hst_addr);
    assign any_stb = |(xcfg_read | xcfg_write);

    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xcfg_read | xcfg_write));

    assert_stb_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> (a32 < WIN_BASE));

    assert_reg_no_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((hst_read || hst_write) && a32 >= WIN_BASE) |-> !hst_waitreq);

    assert_stall_only_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hst_waitreq |-> any_stb);

    assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_read && !hst_waitreq) |=> (hst_rdata == '0));

    assert_rst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_write |=> $stable(rx_reset));
endmodule

bind phyb_ctrl_bridge phyb_ctrl_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .WIN_AW(WIN_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hst_addr    (hst_addr),
    .hst_read    (hst_read),
    .hst_write   (hst_write),
    .hst_waitreq (hst_waitreq),
    .hst_rdata   (hst_rdata),
    .xcfg_read   (xcfg_read),
    .xcfg_write  (xcfg_write),
    .rx_reset    (rx_reset)
);

// File: tb/sim_phyb_ctrl_bridge.sv
module sim_phyb_ctrl_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hst_addr = '0;
    logic        hst_read = 1'b0, hst_write = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_waitreq;
    logic [9:0]  xcfg_addr;
    logic [31:0] xcfg_wdata;
    logic [2:0]  xcfg_read, xcfg_write;
    logic [95:0] xcfg_rdata;
    logic [2:0]  xcfg_waitreq;
    logic [31:0] meas_count = '0;
    logic        meas_ok = 1'b0, cal_done = 1'b0, cal_busy = 1'b0;
    logic        rx_reset;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;
    int wait_left [3];
    int wr_count = 0, last_wr_port = -1;
    logic [9:0]  last_wr_addr;
    logic [31:0] last_wr_data;

    always #4 clk = ~clk;

    phyb_ctrl_bridge u0 (.*);

    // Reconfiguration port models
    for (genvar g = 0; g < 3; g++) begin : g_mdl
        assign xcfg_rdata[g*32 +: 32] = 32'hC000_0000 | (32'(g) << 16) | 32'(xcfg_addr);
        assign xcfg_waitreq[g] = (wait_left[g] != 0);
        always @(posedge clk) begin
            if ((xcfg_read[g] || xcfg_write[g]) && wait_left[g] > 0)
                wait_left[g] <= wait_left[g] - 1;
            if (xcfg_write[g] && !xcfg_waitreq[g]) begin
                wr_count     <= wr_count + 1;
                last_wr_port <= g;
                last_wr_addr <= xcfg_addr;
                last_wr_data <= xcfg_wdata;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // One host access; returns read data and stall cycles
    task automatic access(bit rd, logic [15:0] a, logic [31:0] d,
                          output logic [31:0] rdat, output int stalls);
        stalls = 0;
        @(negedge clk);
        hst_addr = a; hst_read = rd; hst_write = !rd; hst_wdata = d;
        #1;
        while (hst_waitreq) begin
            @(negedge clk); #1;
            stalls++;
        end
        @(negedge clk);
        hst_read = 1'b0; hst_write = 1'b0;
        rdat = hst_rdata;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        logic [31:0] r; int s;
        access(0, a, d, r, s);
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        logic [31:0] r; int s;
        access(1, a, '0, r, s);
        chk(req, r, exp);
    endtask

    task automatic t_reset();
        chk("R7 reset", 32'(rx_reset), 0);
        chk("R6 reset rdata", hst_rdata, 0);
        rd_chk("R2 chan reset", 16'h1040, 0);
        rd_chk("R3 enable reset", 16'h1050, 0);
        rd_chk("R7 rst reg reset", 16'h1060, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] r; int s, n;
        n = wr_count;
        access(0, 16'h0400, 32'h1234_5678, r, s);
        chk("R3 disabled no write", 32'(wr_count - n), 0);
        chk("R4 disabled no stall", 32'(s), 0);
        access(1, 16'h0400, '0, r, s);
        chk("R4 disabled read zero", r, 0);
    endtask

    task automatic t_forward_basic();
        logic [31:0] r; int s;
        wr(16'h1050, 1);
        wr(16'h1040, 0);
        access(0, 16'h0400, 32'hA5A5_0F0F, r, s);
        chk("R1 write port", 32'(last_wr_port), 0);
        chk("R1 write offset", 32'(last_wr_addr), 32'h100);
        chk("R1 write data", last_wr_data, 32'hA5A5_0F0F);
        chk("R6 rdata zero after write", r, 0);
        access(1, 16'h0804, '0, r, s);
        chk("R1 read data", r, 32'hC000_0201);
    endtask

    task automatic t_stall_chan2();
        logic [31:0] r; int s;
        wr(16'h1040, 2);
        wait_left[2] = 3;
        access(1, 16'h0FFC, '0, r, s);
        chk("R5 stall cycles", 32'(s), 3);
        chk("R2 chan2 read data", r, 32'hC002_03FF);
        access(0, 16'h0010, 32'h0000_BEEF, r, s);
        chk("R2 chan2 write port", 32'(last_wr_port), 2);
        chk("R1 offset shift", 32'(last_wr_addr), 32'h004);
    endtask

    task automatic t_chan3();
        logic [31:0] r; int s, n;
        wr(16'h1040, 3);
        n = wr_count;
        access(0, 16'h0020, 32'hFFFF_FFFF, r, s);
        chk("R4 chan3 write dropped", 32'(wr_count - n), 0);
        access(1, 16'h0020, '0, r, s);
        chk("R4 chan3 read zero", r, 0);
        chk("R4 chan3 no stall", 32'(s), 0);
    endtask

    task automatic t_reserved();
        wr(16'h1040, 32'hFFFF_FFF1);
        rd_chk("R11 chan upper bits", 16'h1040, 1);
        wr(16'h1050, 32'hFFFF_FFFF);
        rd_chk("R11 enable upper bits", 16'h1050, 1);
    endtask

    task automatic t_rxreset();
        wr(16'h1060, 1);
        chk("R7 rx_reset set", 32'(rx_reset), 1);
        rd_chk("R7 read back", 16'h1060, 1);
        wr(16'h1060, 0);
        chk("R7 rx_reset clear", 32'(rx_reset), 0);
    endtask

    task automatic t_status();
        meas_count = 32'hDEAD_BEEF; meas_ok = 1; cal_done = 1; cal_busy = 0;
        rd_chk("R9 meas", 16'h1000, 32'hDEAD_BEEF);
        rd_chk("R9 valid", 16'h1010, 1);
        rd_chk("R9 cal done", 16'h1020, 1);
        rd_chk("R9 cal busy", 16'h1030, 0);
        cal_busy = 1; meas_ok = 0;
        rd_chk("R9 cal busy set", 16'h1030, 1);
        rd_chk("R9 valid clear", 16'h1010, 0);
        wr(16'h1000, 32'h0);
        rd_chk("R11 read-only meas", 16'h1000, 32'hDEAD_BEEF);
    endtask

    task automatic t_config();
        rd_chk("R10 cfg", 16'h10B0, 0);
        wr(16'h10B0, 1);
        rd_chk("R10 cfg after write", 16'h10B0, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r; int s;
        access(0, 16'h1080, 32'hFFFF_FFFF, r, s);
        chk("R12 unmapped write no stall", 32'(s), 0);
        rd_chk("R12 unmapped read", 16'h1080, 0);
        wr(16'h1044, 32'h2);
        wr(16'h2040, 32'h2);
        rd_chk("R12 chan untouched", 16'h1040, 1);
        rd_chk("R12 high unmapped read", 16'h2000, 0);
    endtask

    task automatic t_mirror();
        logic [31:0] r; int s;
        wait_left[1] = 5;
        access(1, 16'h1070, '0, r, s);
        chk("R8 mirror high", r, 1);
        chk("R12 mirror no stall", 32'(s), 0);
        access(1, 16'h0100, '0, r, s);
        chk("R5 stall chan1", 32'(s), 5);
        chk("R5 chan1 data", r, 32'hC001_0040);
        rd_chk("R8 mirror low", 16'h1070, 0);
        wait_left[1] = 2;
        wr(16'h1040, 3);
        rd_chk("R8 mirror chan3", 16'h1070, 0);
        wait_left[1] = 0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) wait_left[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_forward_basic();
        t_stall_chan2();
        t_chan3();
        t_reserved();
        t_rxreset();
        t_status();
        t_config();
        t_unmapped();
        t_mirror();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule